// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry-Out

This block shifts or rotates a 32-bit operand by a distance that comes from a general register, and it works out the carry flag that such an operation leaves behind. It sits in the execute stage of a processor datapath, beside the adder. The caller supplies the operand, the register that holds the distance, a two-bit operation code and the present carry flag. The block returns the shifted value, the carry flag to write back and a strobe. The strobe tells the flag logic whether the operation touched the carry at all.

Only the low eight bits of the distance register count, so the distance runs from 0 to 255. Distances of exactly the word width, distances beyond it, and rotates by whole multiples of the word width each have their own result and carry rules, and the block covers them all. A distance of zero passes the operand through unchanged and keeps the incoming carry. The block is purely combinational and holds no state. It is built from three stages. The first stage decodes the distance. The second forms every shift variant on a widened word, so that the bit shifted out falls into a spare position. The third selects the variant and merges the carry.

Top module: `regamt_shifter`

## Requirements
- R1: Only bits [7:0] of `amt_reg` form the distance; bits above them have no effect on any output.
- R2: With a distance of zero, `result` equals `op_in`, `carry_out` equals `carry_in` and `carry_upd` is low, for every operation code.
- R3: `carry_upd` is high whenever the distance is nonzero, and `carry_out` equals `carry_in` whenever `carry_upd` is low.
- R4: Code 00 is logical left: for distances 1 to 31, `result` is `op_in` shifted left and `carry_out` is `op_in` bit (32 - distance).
- R5: Logical left by exactly 32 gives `result` 0 with `carry_out` equal to `op_in` bit 0; beyond 32 both are 0.
- R6: Code 01 is logical right: for distances 1 to 31 `carry_out` is `op_in` bit (distance - 1); at exactly 32 `result` is 0 and `carry_out` is bit 31; beyond 32 both are 0.
- R7: Code 10 is arithmetic right: for distances 1 to 31 the vacated bits take the sign and `carry_out` is `op_in` bit (distance - 1); at 32 or more every result bit and `carry_out` equal the sign bit.
- R8: Code 11 is rotate right by the distance modulo 32: for a nonzero reduced distance `carry_out` is `op_in` bit (reduced distance - 1).
- R9: Rotate right by a nonzero multiple of 32 (32, 64, ... 224) leaves `result` equal to `op_in` and sets `carry_out` to `op_in` bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_in | input | 32 | Value to shift |
| amt_reg | input | 32 | Register holding the distance; low 8 bits used |
| kind | input | 2 | Operation: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| carry_in | input | 1 | Present carry flag |
| result | output | 32 | Shifted or rotated value |
| carry_out | output | 1 | Carry flag to write back |
| carry_upd | output | 1 | High when the operation changes the carry |

## Verification
Some rules are checked on every evaluation by the bound assertions. When the distance is zero, the operand passes through and the carry is held. The strobe follows the distance. A rotate always leaves the carry equal to the result's top bit. Shifts of 32 or more give a sign-filled value for the arithmetic case and zero for the logical cases above 32. The exact bit that lands in the carry for distances 1 to 31 is a different matter. So is the independence from the upper register bits. Only the bench's scenarios show these, where a bit-serial reference model is compared on directed corner distances and on random operands.

// File: rtl/regamt_shifter_pkg.sv
package regamt_shifter_pkg;
    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;
endpackage

// File: rtl/regamt_amt_decode.sv
module regamt_amt_decode #(
    parameter int WIDTH    = 32,
    parameter int REG_W    = 32,
    parameter int AMT_BITS = 8,
    localparam int SH_BITS = $clog2(WIDTH)
) (
    input  logic [REG_W-1:0]    amt_reg,
    output logic [AMT_BITS-1:0] amt,
    output logic [SH_BITS-1:0]  amt_mod,
    output logic                amt_zero
);
    // only the low byte of the register is architecturally meaningful
    assign amt      = amt_reg[AMT_BITS-1:0];
    assign amt_mod  = amt[SH_BITS-1:0];
    assign amt_zero = (amt == '0);
endmodule

// File: rtl/regamt_shift_core.sv
module regamt_shift_core #(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    localparam int SH_BITS = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]    op_in,
    input  logic [AMT_BITS-1:0] amt,
    input  logic [SH_BITS-1:0]  amt_mod,
    output logic [WIDTH:0]      lsl_w,
    output logic [WIDTH:0]      lsr_w,
    output logic [WIDTH:0]      asr_w,
    output logic [WIDTH-1:0]    ror_v
);
    logic [WIDTH:0]     lsl_src;
    logic [WIDTH:0]     rsh_src;
    logic [2*WIDTH-1:0] ror_src;
    logic [2*WIDTH-1:0] ror_sh;

    // widen by one bit so the last bit shifted out lands in a spare slot:
    // bit WIDTH for left shifts, bit 0 for right shifts
    assign lsl_src = {1'b0, op_in};
    assign rsh_src = {op_in, 1'b0};
    assign ror_src = {op_in, op_in};

    assign lsl_w  = lsl_src << amt;
    assign lsr_w  = rsh_src >> amt;
    assign asr_w  = $unsigned($signed(rsh_src) >>> amt);
    assign ror_sh = ror_src >> amt_mod;
    assign ror_v  = ror_sh[WIDTH-1:0];
endmodule

// File: rtl/regamt_carry_merge.sv
module regamt_carry_merge
    import regamt_shifter_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  shift_kind_e      kind,
    input  logic             amt_zero,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] op_in,
    input  logic [WIDTH:0]   lsl_w,
    input  logic [WIDTH:0]   lsr_w,
    input  logic [WIDTH:0]   asr_w,
    input  logic [WIDTH-1:0] ror_v,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             carry_upd
);
    logic [WIDTH-1:0] sel_v;
    logic             sel_c;

    always_comb begin
        unique case (kind)
            SK_LSL: begin
                sel_v = lsl_w[WIDTH-1:0];
                sel_c = lsl_w[WIDTH];
            end
            SK_LSR: begin
                sel_v = lsr_w[WIDTH:1];
                sel_c = lsr_w[0];
            end
            SK_ASR: begin
                sel_v = asr_w[WIDTH:1];
                sel_c = asr_w[0];
            end
            SK_ROR: begin
                // the last bit rotated out is the new top bit, including
                // the whole-multiple case where the value is unchanged
                sel_v = ror_v;
                sel_c = ror_v[WIDTH-1];
            end
            default: begin
                sel_v = op_in;
                sel_c = carry_in;
            end
        endcase
    end

    assign result    = amt_zero ? op_in : sel_v;
    assign carry_out = amt_zero ? carry_in : sel_c;
    assign carry_upd = !amt_zero;
endmodule

// File: rtl/regamt_shifter.sv
module regamt_shifter
    import regamt_shifter_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int REG_W    = 32,
    parameter int AMT_BITS = 8,
    localparam int SH_BITS = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] op_in,
    input  logic [REG_W-1:0] amt_reg,
    input  logic [1:0]       kind,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             carry_upd
);
    logic [AMT_BITS-1:0] amt;
    logic [SH_BITS-1:0]  amt_mod;
    logic                amt_zero;
    logic [WIDTH:0]      lsl_w;
    logic [WIDTH:0]      lsr_w;
    logic [WIDTH:0]      asr_w;
    logic [WIDTH-1:0]    ror_v;

    regamt_amt_decode #(
        .WIDTH(WIDTH), .REG_W(REG_W), .AMT_BITS(AMT_BITS)
    ) u_dec (
        .amt_reg (amt_reg),
        .amt     (amt),
        .amt_mod (amt_mod),
        .amt_zero(amt_zero)
    );

    regamt_shift_core #(
        .WIDTH(WIDTH), .AMT_BITS(AMT_BITS)
    ) u_core (
        .op_in  (op_in),
        .amt    (amt),
        .amt_mod(amt_mod),
        .lsl_w  (lsl_w),
        .lsr_w  (lsr_w),
        .asr_w  (asr_w),
        .ror_v  (ror_v)
    );

    regamt_carry_merge #(
        .WIDTH(WIDTH)
    ) u_merge (
        .kind     (shift_kind_e'(kind)),
        .amt_zero (amt_zero),
        .carry_in (carry_in),
        .op_in    (op_in),
        .lsl_w    (lsl_w),
        .lsr_w    (lsr_w),
        .asr_w    (asr_w),
        .ror_v    (ror_v),
        .result   (result),
        .carry_out(carry_out),
        .carry_upd(carry_upd)
    );
endmodule

// File: rtl/regamt_shifter_chk.sv
module regamt_shifter_chk #(
    parameter int WIDTH    = 32,
    parameter int REG_W    = 32,
    parameter int AMT_BITS = 8
) (
    input logic [WIDTH-1:0] op_in,
    input logic [REG_W-1:0] amt_reg,
    input logic [1:0]       kind,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             carry_upd
);
    localparam logic [AMT_BITS-1:0] W_AMT = AMT_BITS'(WIDTH);
    logic [AMT_BITS-1:0] a;
    assign a = amt_reg[AMT_BITS-1:0];

    always_comb begin
        if (a == '0) begin
            assert_zero_pass_R2: assert (result == op_in && !carry_upd);
        end
        assert_upd_tracks_R3: assert (carry_upd == (a != '0));
        if (!carry_upd) begin
            assert_carry_hold_R3: assert (carry_out == carry_in);
        end
        if (kind == 2'b11 && a != '0) begin
            assert_ror_carry_R8: assert (carry_out == result[WIDTH-1]);
        end
        if (kind == 2'b10 && a >= W_AMT) begin
            assert_asr_fill_R7: assert (result == {WIDTH{op_in[WIDTH-1]}}
                                        && carry_out == op_in[WIDTH-1]);
        end
        if (kind[1] == 1'b0 && a > W_AMT) begin
            assert_logic_clear_R5: assert (result == '0 && !carry_out);
        end
    end
endmodule

bind regamt_shifter regamt_shifter_chk #(
    .WIDTH(WIDTH), .REG_W(REG_W), .AMT_BITS(AMT_BITS)
) u_chk (
    .op_in    (op_in),
    .amt_reg  (amt_reg),
    .kind     (kind),
    .carry_in (carry_in),
    .result   (result),
    .carry_out(carry_out),
    .carry_upd(carry_upd)
);

// File: tb/regamt_shifter_tb.sv
module regamt_shifter_tb;
    logic        clk = 1'b0;
    logic [31:0] op_in = '0;
    logic [31:0] amt_reg = '0;
    logic [1:0]  kind = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out;
    logic        carry_upd;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    regamt_shifter u_dut (
        .op_in(op_in), .amt_reg(amt_reg), .kind(kind), .carry_in(carry_in),
        .result(result), .carry_out(carry_out), .carry_upd(carry_upd)
    );

    // bit-serial reference: one position per step
    function automatic logic [33:0] ref_model(logic [31:0] x, logic [7:0] n,
                                              logic [1:0] k, logic c);
        logic [31:0] v = x;
        logic cc = c;
        for (int i = 0; i < int'(n); i++) begin
            case (k)
                2'b00: begin cc = v[31]; v = {v[30:0], 1'b0}; end
                2'b01: begin cc = v[0];  v = {1'b0, v[31:1]}; end
                2'b10: begin cc = v[0];  v = {v[31], v[31:1]}; end
                default: begin cc = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {n != 8'd0, cc, v};
    endfunction

    function automatic string tag_of(logic [7:0] n, logic [1:0] k);
        if (n == 0) return "R2";
        case (k)
            2'b00: return (n < 32) ? "R4" : "R5";
            2'b01: return "R6";
            2'b10: return "R7";
            default: return (n[4:0] == 0) ? "R9" : "R8";
        endcase
    endfunction

    task automatic apply(input logic [31:0] x, input logic [31:0] ar,
                         input logic [1:0] k, input logic c, input string tag);
        logic [33:0] exp;
        @(posedge clk);
        op_in = x; amt_reg = ar; kind = k; carry_in = c;
        @(negedge clk);
        exp = ref_model(x, ar[7:0], k, c);
        total++;
        if ({carry_upd, carry_out, result} !== exp) begin
            bad++;
            $display("FAIL %s kind=%0d amt=%0d op=%h: got upd=%b c=%b r=%h exp upd=%b c=%b r=%h",
                     tag, k, ar[7:0], x, carry_upd, carry_out, result,
                     exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic run(input logic [31:0] x, input logic [7:0] n,
                       input logic [1:0] k, input logic c);
        apply(x, {24'h0, n}, k, c, tag_of(n, k));
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // idle state: all zero inputs (R2)
        @(negedge clk);
        total++;
        if (result !== 32'h0 || carry_out !== 1'b0 || carry_upd !== 1'b0) begin
            bad++;
            $display("FAIL R2 idle: got r=%h c=%b u=%b exp 0 0 0", result, carry_out, carry_upd);
        end
        for (int k = 0; k < 4; k++) begin
            // R2/R3 zero distance keeps carry for both polarities
            run(32'hA5A5_0F0F, 8'd0, 2'(k), 1'b1);
            run(32'hA5A5_0F0F, 8'd0, 2'(k), 1'b0);
            // corner distances
            run(32'h8000_0001, 8'd1, 2'(k), 1'b0);
            run(32'h8000_0001, 8'd31, 2'(k), 1'b0);
            run(32'h8000_0001, 8'd32, 2'(k), 1'b0);
            run(32'h7FFF_FFFE, 8'd32, 2'(k), 1'b1);
            run(32'hFFFF_FFFF, 8'd33, 2'(k), 1'b1);
            run(32'h8000_0000, 8'd200, 2'(k), 1'b0);
            run(32'hC000_0003, 8'd64, 2'(k), 1'b0);
            run(32'h4000_0002, 8'd224, 2'(k), 1'b0);
            run(32'h1234_5678, 8'd255, 2'(k), 1'b1);
            // R1: upper register bits must not matter
            apply(32'hDEAD_BEEF, 32'hFFFF_FF00, 2'(k), 1'b1, "R1");
            apply(32'hDEAD_BEEF, 32'h0101_0004, 2'(k), 1'b0, "R1");
        end
        // R3: nonzero distance raises update with carry_in irrelevant
        apply(32'h0000_0001, 32'h0000_0001, 2'b01, 1'b0, "R3");
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x = $urandom;
            logic [31:0] ar = $urandom;
            logic [1:0]  k = 2'($urandom);
            logic        c = 1'($urandom);
            if (i % 2 == 0) ar[7:0] = 8'($urandom % 40);
            apply(x, ar, k, c, (ar[31:8] != 0) ? "R1" : tag_of(ar[7:0], k));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule